// File: doc/BRIEF.md
# Coherent Multi-Register Time Snapshot Reader

This block is a small bus master that pulls a consistent picture of a clock peripheral's counter digits, even when the read sequence is slow and the counter may roll over part way through. The peripheral holds a chain of 4-bit BCD digit registers. Register 0 is the lowest-order digit. A higher-order digit can only change when every digit below it changes as well.

On a request, the reader does three things in turn. It reads register 0 and keeps that value as a reference. It then reads every other register that the select mask asks for. Last, it reads register 0 again and compares the result with the reference. If the two values are equal, nothing rolled over during the pass, so the collected digits form a valid snapshot. The reader publishes them and pulses done.

If the two values differ, the second value becomes the new reference and the other registers are read again. A retry cap bounds this loop. When every allowed pass fails, the reader ends with an error flag instead of a snapshot. Each read waits for the peripheral's ready, so any read latency is accepted.

Top module: `coherent_snap`

## Requirements
- R1: After reset, done and err are 0, snapshot is all zeros, and rdStrobe is 0.
- R2: The first read of every request is register 0. Register 0 is always read and always lands in snapshot field 0, whatever bit 0 of selMask holds.
- R3: Inside a pass, register i for i in 1..NUM_REGS-1 is read only when selMask bit i (latched at request) is 1, and such reads go in strictly ascending index. Snapshot field i sits at bits [4i+3:4i]. Fields of unselected registers read as 0.
- R4: Every pass ends with a read of register 0. If it equals the reference, the snapshot is published with err=0 and done pulses in the cycle after that read's ready handshake.
- R5: If the closing register-0 value differs from the reference, that value becomes the new reference and all selected registers are read again. The published snapshot holds the values of the matching pass.
- R6: rdStrobe stays high and rdAddr stays stable until rdReady is seen. rdData is captured only in a cycle where rdStrobe and rdReady are both high.
- R7: If MAX_TRIES passes in a row all mismatch, done pulses with err=1 and the snapshot keeps its previously published value.
- R8: Once done has pulsed, snapshot and err hold until the next accepted request. A request raised while a read sequence is running is ignored.
- R9: done is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a snapshot (sampled while idle) |
| selMask | input | NUM_REGS | Registers wanted; bit 0 is ignored |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Retry cap exhausted on last request |
| snapshot | output | NUM_REGS*4 | Published digits, field i at [4i+3:4i] |
| rdAddr | output | IDX_W | Register index being read |
| rdStrobe | output | 1 | Read request, held until ready |
| rdData | input | 4 | Read data, valid with rdReady |
| rdReady | input | 1 | Read completion |

## Verification
Two decisions can fall on the same closing read of register 0: the decision to retry and the decision to give up at the retry cap. The bench's peripheral model advances the BCD counter right after chosen register-0 reads. This lets it place a mismatch on exactly the last allowed pass (MAX_TRIES ticks) and also one pass earlier (MAX_TRIES-1 ticks). It then checks that the first case gives err with the old snapshot kept, and the second gives a valid snapshot of the advanced count. The total number of reads confirms the number of passes in each case.

// File: rtl/snap_pkg.sv
package snap_pkg;
  typedef struct packed {
    logic start;     // latch mask, clear working copy
    logic loadRef;   // capture reference from register 0
    logic loadWork;  // capture a body register at current index
    logic publish;   // copy working set to the output
  } snapCtl_t;
endpackage

// File: rtl/snap_dp.sv
module snap_dp
  import snap_pkg::*;
#(
  parameter int NUM_REGS = 13,
  parameter int DIG_W    = 4,
  parameter int IDX_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  snapCtl_t                  ctl,
  input  logic [IDX_W-1:0]          idx,
  input  logic [NUM_REGS-1:0]       selMask,
  input  logic [DIG_W-1:0]          rdData,
  output logic                      curSel,
  output logic                      match,
  output logic [NUM_REGS*DIG_W-1:0] snapOut
);
  localparam int PAD = 1 << IDX_W;

  logic [NUM_REGS-1:0]       maskReg;
  logic [DIG_W-1:0]          refReg;
  logic [NUM_REGS*DIG_W-1:0] work;
  logic [PAD-1:0]            maskPad;

  assign maskPad = PAD'(maskReg);
  assign curSel  = maskPad[idx];
  assign match   = (rdData == refReg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskReg <= '0;
      refReg  <= '0;
    end else begin
      if (ctl.start)   maskReg <= selMask;
      if (ctl.loadRef) refReg  <= rdData;
    end
  end

  // field 0 follows the reference; others load on their own index
  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_field
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          work[g*DIG_W +: DIG_W] <= '0;
        else if (ctl.start)
          work[g*DIG_W +: DIG_W] <= '0;
        else if ((g == 0) ? ctl.loadRef : (ctl.loadWork && idx == IDX_W'(g)))
          work[g*DIG_W +: DIG_W] <= rdData;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           snapOut <= '0;
    else if (ctl.publish) snapOut <= work;
  end

  // R5: a published field 0 always equals the reference it was compared to
  a_r5_pub_ref: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.publish |=> snapOut[DIG_W-1:0] == $past(refReg));
  // R8: output changes only on a publish strobe
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.publish |=> $stable(snapOut));
endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl
  import snap_pkg::*;
#(
  parameter int NUM_REGS  = 13,
  parameter int MAX_TRIES = 4,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             curSel,
  input  logic             match,
  input  logic             rdReady,
  output snapCtl_t         ctl,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] rdAddr,
  output logic             rdStrobe,
  output logic             done,
  output logic             err
);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

  typedef enum logic [1:0] {S_IDLE, S_REF, S_BODY, S_CHK} state_t;
  state_t state, nxtState;
  logic [TRY_W-1:0] tries;
  logic             xfer;

  assign rdAddr   = (state == S_BODY) ? idx : '0;
  assign rdStrobe = (state == S_REF) || (state == S_CHK) || (state == S_BODY && curSel);
  assign xfer     = rdStrobe && rdReady;

  always_comb begin
    ctl      = '0;
    nxtState = state;
    unique case (state)
      S_IDLE: if (req) begin ctl.start = 1'b1; nxtState = S_REF; end
      S_REF:  if (xfer) begin ctl.loadRef = 1'b1; nxtState = S_BODY; end
      S_BODY: begin
        ctl.loadWork = xfer;
        if ((!curSel || rdReady) && idx == LAST) nxtState = S_CHK;
      end
      S_CHK: if (xfer) begin
        if (match) begin ctl.publish = 1'b1; nxtState = S_IDLE; end
        else if (tries == TRY_W'(MAX_TRIES)) nxtState = S_IDLE;
        else begin ctl.loadRef = 1'b1; nxtState = S_BODY; end
      end
      default: nxtState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      tries <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= nxtState;
      done  <= 1'b0;
      if (ctl.start) begin
        tries <= TRY_W'(1);
        err   <= 1'b0;
      end
      if (ctl.loadRef) idx <= IDX_W'(1);
      if (state == S_BODY && (!curSel || rdReady) && idx != LAST) idx <= idx + 1'b1;
      if (state == S_CHK && xfer) begin
        if (match) done <= 1'b1;
        else if (tries == TRY_W'(MAX_TRIES)) begin done <= 1'b1; err <= 1'b1; end
        else tries <= tries + 1'b1;
      end
    end
  end

  // R6: a pending read keeps its strobe and address
  a_r6_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rdStrobe && !rdReady |=> rdStrobe && $stable(rdAddr));
  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: error only after the cap, and pass count never exceeds it
  a_r7_err_cap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> tries == TRY_W'(MAX_TRIES));
  a_r7_tries_max: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= TRY_W'(MAX_TRIES));
  // R4: a clean finish follows a matching closing read
  a_r4_done_match: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> $past(match) && $past(rdReady));
endmodule

// File: rtl/coherent_snap.sv
module coherent_snap
  import snap_pkg::*;
#(
  parameter int NUM_REGS  = 13,
  parameter int MAX_TRIES = 4,
  parameter int DIG_W     = 4,
  parameter int IDX_W     = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req,
  input  logic [NUM_REGS-1:0]       selMask,
  output logic                      done,
  output logic                      err,
  output logic [NUM_REGS*DIG_W-1:0] snapshot,
  output logic [IDX_W-1:0]          rdAddr,
  output logic                      rdStrobe,
  input  logic [DIG_W-1:0]          rdData,
  input  logic                      rdReady
);
  snapCtl_t         ctl;
  logic [IDX_W-1:0] idx;
  logic             curSel;
  logic             match;

  snap_ctrl #(.NUM_REGS(NUM_REGS), .MAX_TRIES(MAX_TRIES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .curSel(curSel), .match(match),
    .rdReady(rdReady), .ctl(ctl), .idx(idx), .rdAddr(rdAddr),
    .rdStrobe(rdStrobe), .done(done), .err(err));

  snap_dp #(.NUM_REGS(NUM_REGS), .DIG_W(DIG_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .idx(idx), .selMask(selMask),
    .rdData(rdData), .curSel(curSel), .match(match), .snapOut(snapshot));
endmodule

// File: tb/coherent_snap_bench.sv
module coherent_snap_bench;
  localparam int N  = 13;
  localparam int MT = 4;

  logic clk = 0, rst_n = 0, req = 0;
  logic [N-1:0] selMask = '0;
  logic done, err, rdStrobe, rdReady;
  logic [N*4-1:0] snapshot;
  logic [3:0] rdAddr, rdData;

  coherent_snap u_coherent_snap (
    .clk(clk), .rst_n(rst_n), .req(req), .selMask(selMask), .done(done),
    .err(err), .snapshot(snapshot), .rdAddr(rdAddr), .rdStrobe(rdStrobe),
    .rdData(rdData), .rdReady(rdReady));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [3:0] mem [N];
  int ticksLeft = 0, readCount = 0, lastBody = 0, lastAddr = 0, firstAddr = -1;
  bit badOrder = 0;
  logic [3:0] srvAddr = 0;
  int delay = 0;
  logic [N*4-1:0] lastSnap = '0;

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tickMem();
    for (int i = 0; i < N; i++) begin
      if (mem[i] == 4'd9) mem[i] = 4'd0;
      else begin mem[i] = mem[i] + 4'd1; break; end
    end
  endtask

  function automatic logic [N*4-1:0] expSnap(logic [N-1:0] m);
    logic [N*4-1:0] s = '0;
    for (int i = 0; i < N; i++)
      if (i == 0 || m[i]) s[i*4 +: 4] = mem[i];
    return s;
  endfunction

  function automatic int bodyCount(logic [N-1:0] m);
    int c = 0;
    for (int i = 1; i < N; i++) c += m[i];
    return c;
  endfunction

  // peripheral model: random latency, garbage data while not ready
  initial begin
    rdReady = 0; rdData = 0;
    forever begin
      @(negedge clk);
      if (rdReady) begin
        rdReady = 0;
        readCount++;
        if (readCount == 1) firstAddr = srvAddr;
        lastAddr = srvAddr;
        if (srvAddr == 0) begin
          lastBody = 0;
          if (ticksLeft > 0) begin tickMem(); ticksLeft--; end
        end else begin
          if (!selMask[srvAddr] || srvAddr <= lastBody) badOrder = 1;
          lastBody = srvAddr;
        end
        rdData = 4'($urandom);
      end else if (rdStrobe) begin
        if (delay == 0) begin
          rdReady = 1; srvAddr = rdAddr; rdData = mem[rdAddr];
          delay = $urandom % 4;
        end else begin
          delay--; rdData = 4'($urandom);
        end
      end else rdData = 4'($urandom);
    end
  end

  task automatic runTx(logic [N-1:0] m, int b, int hold, string tag);
    int cyc = 0;
    int passes;
    logic [N*4-1:0] exp;
    selMask = m; ticksLeft = b; readCount = 0; lastBody = 0;
    badOrder = 0; firstAddr = -1;
    @(negedge clk); req = 1;
    repeat (hold) @(negedge clk);
    req = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    if (!done) begin check(0, {tag, " watchdog"}, cyc, 0); return; end
    passes = (b >= MT) ? MT : b + 1;
    if (b >= MT) begin
      check(err == 1, {tag, " R7 err"}, err, 1);
      check(snapshot == lastSnap, {tag, " R7 snapshot kept"}, snapshot, lastSnap);
    end else begin
      exp = expSnap(m);
      check(err == 0, {tag, " R4 err"}, err, 0);
      check(snapshot == exp, {tag, " R4/R5 snapshot"}, snapshot, exp);
      lastSnap = exp;
    end
    check(readCount == 1 + passes * (bodyCount(m) + 1), {tag, " R5/R8 read count"},
          readCount, 1 + passes * (bodyCount(m) + 1));
    check(firstAddr == 0, {tag, " R2 first read"}, firstAddr, 0);
    check(lastAddr == 0, {tag, " R4 last read"}, lastAddr, 0);
    check(!badOrder, {tag, " R3 order"}, badOrder, 0);
    @(negedge clk);
    check(done == 0, {tag, " R9 pulse width"}, done, 0);
    repeat (3) @(negedge clk);
    check(snapshot == lastSnap && err == (b >= MT), {tag, " R8 stable"}, snapshot, lastSnap);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd7001);
    for (int i = 0; i < N; i++) mem[i] = 4'($urandom % 10);
    repeat (3) @(negedge clk);
    check(done == 0 && err == 0 && snapshot == '0 && rdStrobe == 0, "R1 reset", snapshot, 0);
    rst_n = 1;
    runTx('1, 0, 1, "all-regs");
    runTx(13'h0001, 0, 1, "R2 only-reg0");
    runTx(13'h0000, 1, 1, "R2 mask-bit0-clear");
    runTx(13'h0AA2, 0, 1, "R3 sparse");
    for (int i = 0; i < N; i++) mem[i] = 4'd9;
    runTx('1, 1, 1, "R5 rollover");
    runTx(13'h1235, MT - 1, 3, "R5/R8 last-try");
    runTx(13'h1F0E, MT, 1, "R7 cap");
    runTx(13'h00FF, MT + 2, 2, "R7 cap-extra");
    runTx(13'h0F0F, 0, 1, "R7 recover");
    for (int t = 0; t < 20; t++)
      runTx(N'($urandom), $urandom % (MT + 2), 1 + $urandom % 3, "random");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule